// File: doc/BRIEF.md
# I2C Event Status and Interrupt Aggregator

This block gathers the individual event conditions of an I2C controller into sticky flags, a summary event bit and an interrupt request. It also decides when the controller must stretch SCL low. The protocol engine reports each event as a one-cycle pulse on a nine-bit vector and presents three mode levels: transmitting, bus busy and master. Software configures the block through the peripheral-enable, ACK-enable and interrupt-enable controls. It reads two status bytes through a read strobe with a one-bit select, and each read clears the event flags held in that byte.

The summary event bit stays set while any event flag is set, and clears only after all of them have been cleared. A byte-transfer-finished event normally stretches SCL. When DMA is enabled, that event stretches SCL only after the DMA reports completion. If an event arrives in the same cycle as the read that clears its flag, the read returns the flag, the flag clears, and no interrupt is raised for that event.

Top module: `i2c_evt_status`

## Requirements
- R1: After reset, `sr1`, `sr2`, `rd_data`, `irq` and `scl_hold` are all 0.
- R2: A pulse on `ev[i]` sets a sticky flag that is visible in the status bytes after the next clock edge. The encoding is: `ev[0]` start generated → `sr1[0]`; `ev[1]` address matched → `sr1[2]`; `ev[2]` byte transfer finished → `sr1[3]`; `ev[3]` 10-bit header sent → `sr1[6]`; `ev[4]` address transmitted → `sr2[0]`; `ev[5]` bus error → `sr2[1]`; `ev[6]` arbitration lost → `sr2[2]`; `ev[7]` stop detected → `sr2[3]`; `ev[8]` no acknowledge → `sr2[4]`. Bits `sr2[7:5]` read 0.
- R3: `sr1[7]` is the summary event bit. It is 1 exactly while at least one of the nine event flags is set. The mode bits do not contribute to it.
- R4: An address-matched pulse (`ev[1]`) is ignored while `ack_en` is 0.
- R5: When `rd_stb` is high, `rd_data` captures the selected byte on that clock edge (`rd_sel`=0 selects `sr1`, 1 selects `sr2`). On the same edge, every event flag held in the selected byte is cleared.
- R6: If an event pulse coincides with a read that clears its flag, `rd_data` shows the flag and the summary bit as 1. The flag is then 0, and `irq` does not rise.
- R7: `irq` is a registered level equal to interrupt-enable AND the summary bit, one clock after they change.
- R8: Interrupt-enable is loaded from `ie_wdata` when `ie_we` is high. It is forced to 0 while `pe` is 0, and it stays 0 after `pe` returns to 1 until software writes it again.
- R9: While `pe` is 0, all event flags and mode bits are cleared on each clock edge, so `sr1` and `sr2` read 0.
- R10: `scl_hold` is registered. One clock after any of the start-generated, address-matched, byte-transfer-finished, 10-bit-header or address-transmitted flags is set, it goes to 1. It falls one clock after they clear.
- R11: While `dma_en` is 1 and `dma_done` is 0, the byte-transfer-finished flag does not cause `scl_hold`. Once `dma_done` rises, it does.
- R12: The mode levels appear as registered bits `sr1[5]` (transmitting), `sr1[4]` (bus busy) and `sr1[1]` (master), one clock after the inputs. Reads do not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe | input | 1 | Peripheral enable |
| ack_en | input | 1 | Acknowledge enable; gates address-match events |
| ie_we | input | 1 | Write strobe for interrupt-enable |
| ie_wdata | input | 1 | Value written to interrupt-enable |
| dma_en | input | 1 | DMA enabled for data bytes |
| dma_done | input | 1 | DMA transfer complete |
| ev | input | 9 | One-cycle event pulses (encoding in R2) |
| lv_tx | input | 1 | Transmitter mode level |
| lv_busy | input | 1 | Bus busy level |
| lv_master | input | 1 | Master mode level |
| rd_stb | input | 1 | Status read strobe |
| rd_sel | input | 1 | Status byte select (0 first, 1 second) |
| sr1 | output | 8 | Status byte 1 |
| sr2 | output | 8 | Status byte 2 |
| rd_data | output | 8 | Byte captured by the last read |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The bench builds the block with its package defaults: nine events and 8-bit status bytes. At this size every single event can be swept individually under both interrupt-enable settings, and each one is cleared through its own status byte. All four combinations of DMA enable and completion are applied to the byte-transfer-finished stretch rule. A read that coincides with an event, a masked address match, the mode levels, and the disable-and-reenable path that clears interrupt-enable are each driven directly at the ports.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int NUM_EVT = 9;
  localparam int SR_W    = 8;

  // event vector positions
  localparam int EV_START    = 0;
  localparam int EV_ADMATCH  = 1;
  localparam int EV_BTF      = 2;
  localparam int EV_HDR10    = 3;
  localparam int EV_ADDRSENT = 4;
  localparam int EV_BUSERR   = 5;
  localparam int EV_ARBLOST  = 6;
  localparam int EV_STOP     = 7;
  localparam int EV_NACK     = 8;

  // flags that belong to the second status byte
  localparam logic [NUM_EVT-1:0] SR2_OWNED = 9'b1_1111_0000;
  // flags that stretch SCL unconditionally
  localparam logic [NUM_EVT-1:0] HOLD_FIXED = 9'b0_0001_1011;

  typedef struct packed {
    logic tx;
    logic busy;
    logic master;
  } mode_t;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pe,
  input  logic [N-1:0] set,
  input  logic [N-1:0] rd_clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic flag_r;
    always_ff @(posedge clk) begin
      if (rst || !pe)      flag_r <= 1'b0;
      else if (rd_clr[i])  flag_r <= 1'b0;   // read clear beats a coincident set
      else if (set[i])     flag_r <= 1'b1;
    end
    assign q[i] = flag_r;

    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
      rd_clr[i] |=> !q[i]);
  end
endmodule

// File: rtl/evt_status_pack.sv
module evt_status_pack
  import i2c_evt_pkg::*;
(
  input  logic [NUM_EVT-1:0] flags,
  input  mode_t              mode,
  output logic [SR_W-1:0]    byte1,
  output logic [SR_W-1:0]    byte2
);
  logic any_evt;
  assign any_evt = |flags;

  always_comb begin
    byte1 = '0;
    byte1[7] = any_evt;
    byte1[6] = flags[EV_HDR10];
    byte1[5] = mode.tx;
    byte1[4] = mode.busy;
    byte1[3] = flags[EV_BTF];
    byte1[2] = flags[EV_ADMATCH];
    byte1[1] = mode.master;
    byte1[0] = flags[EV_START];

    byte2 = '0;
    byte2[4] = flags[EV_NACK];
    byte2[3] = flags[EV_STOP];
    byte2[2] = flags[EV_ARBLOST];
    byte2[1] = flags[EV_BUSERR];
    byte2[0] = flags[EV_ADDRSENT];
  end
endmodule

// File: rtl/evt_irq_hold.sv
module evt_irq_hold
  import i2c_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pe,
  input  logic               ie_we,
  input  logic               ie_wdata,
  input  logic               evf,
  input  logic [NUM_EVT-1:0] flags,
  input  logic               dma_en,
  input  logic               dma_done,
  output logic               irq,
  output logic               scl_hold
);
  logic ie_q;
  logic btf_stretch;
  logic fixed_stretch;

  always_ff @(posedge clk) begin
    if (rst || !pe)  ie_q <= 1'b0;
    else if (ie_we)  ie_q <= ie_wdata;
  end

  assign fixed_stretch = |(flags & HOLD_FIXED);
  assign btf_stretch   = flags[EV_BTF] & ~(dma_en & ~dma_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      scl_hold <= 1'b0;
    end else begin
      irq      <= pe & ie_q & evf;
      scl_hold <= pe & (fixed_stretch | btf_stretch);
    end
  end

  // R8
  ie_force_chk: assert property (@(posedge clk) disable iff (rst)
    !pe |=> !ie_q);

  // R11
  dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_en && !dma_done && ((flags & HOLD_FIXED) == '0)) |=> !scl_hold);
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2c_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pe,
  input  logic               ack_en,
  input  logic               ie_we,
  input  logic               ie_wdata,
  input  logic               dma_en,
  input  logic               dma_done,
  input  logic [NUM_EVT-1:0] ev,
  input  logic               lv_tx,
  input  logic               lv_busy,
  input  logic               lv_master,
  input  logic               rd_stb,
  input  logic               rd_sel,
  output logic [SR_W-1:0]    sr1,
  output logic [SR_W-1:0]    sr2,
  output logic [SR_W-1:0]    rd_data,
  output logic               irq,
  output logic               scl_hold
);
  logic [NUM_EVT-1:0] set_w;
  logic [NUM_EVT-1:0] clr_w;
  logic [NUM_EVT-1:0] flags;
  logic [NUM_EVT-1:0] snap_flags;
  logic [SR_W-1:0]    snap1;
  logic [SR_W-1:0]    snap2;
  mode_t              mode_q;

  // address match only counts while acknowledging
  always_comb begin
    set_w = ev;
    set_w[EV_ADMATCH] = ev[EV_ADMATCH] & ack_en;
  end

  assign clr_w = (rd_stb && pe) ? (rd_sel ? SR2_OWNED : ~SR2_OWNED) : '0;

  evt_flag_bank #(.N(NUM_EVT)) u_bank (
    .clk(clk), .rst(rst), .pe(pe), .set(set_w), .rd_clr(clr_w), .q(flags)
  );

  always_ff @(posedge clk) begin
    if (rst || !pe) mode_q <= '0;
    else            mode_q <= '{tx: lv_tx, busy: lv_busy, master: lv_master};
  end

  evt_status_pack u_live (.flags(flags), .mode(mode_q), .byte1(sr1), .byte2(sr2));

  // what a read sees includes events landing in the same cycle
  assign snap_flags = pe ? (flags | set_w) : '0;
  evt_status_pack u_snap (.flags(snap_flags), .mode(mode_q), .byte1(snap1), .byte2(snap2));

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= rd_sel ? snap2 : snap1;
  end

  evt_irq_hold u_irq (
    .clk(clk), .rst(rst), .pe(pe), .ie_we(ie_we), .ie_wdata(ie_wdata),
    .evf(sr1[7]), .flags(flags), .dma_en(dma_en), .dma_done(dma_done),
    .irq(irq), .scl_hold(scl_hold)
  );

  // R9
  evt_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !pe |=> (sr1 == '0 && sr2 == '0));

  // R7
  irq_evt_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(sr1[7]));

  // R3
  evf_sum_chk: assert property (@(posedge clk) disable iff (rst)
    sr1[7] == ((sr1[6] | sr1[3] | sr1[2] | sr1[0]) | (|sr2)));
endmodule

// File: tb/i2c_evt_status_bench.sv
module i2c_evt_status_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pe = 1'b0, ack_en = 1'b0, ie_we = 1'b0, ie_wdata = 1'b0;
  logic dma_en = 1'b0, dma_done = 1'b0;
  logic [8:0] ev = '0;
  logic lv_tx = 1'b0, lv_busy = 1'b0, lv_master = 1'b0;
  logic rd_stb = 1'b0, rd_sel = 1'b0;
  logic [7:0] sr1, sr2, rd_data;
  logic irq, scl_hold;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_evt_status u_i2c_evt_status (
    .clk(clk), .rst(rst), .pe(pe), .ack_en(ack_en), .ie_we(ie_we),
    .ie_wdata(ie_wdata), .dma_en(dma_en), .dma_done(dma_done), .ev(ev),
    .lv_tx(lv_tx), .lv_busy(lv_busy), .lv_master(lv_master),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .sr1(sr1), .sr2(sr2),
    .rd_data(rd_data), .irq(irq), .scl_hold(scl_hold)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected status bytes for a single flag, from the R2 encoding
  function automatic logic [15:0] exp_bytes(input int idx);
    logic [7:0] b1, b2;
    b1 = 8'h00; b2 = 8'h00;
    case (idx)
      0: b1 = 8'h01;
      1: b1 = 8'h04;
      2: b1 = 8'h08;
      3: b1 = 8'h40;
      default: b2 = 8'(1 << (idx - 4));
    endcase
    if (b1 != 0 || b2 != 0) b1 = b1 | 8'h80;  // R3 summary bit
    return {b1, b2};
  endfunction

  task automatic write_ie(input logic v);
    ie_we = 1'b1; ie_wdata = v;
    step();
    ie_we = 1'b0;
  endtask

  task automatic do_read(input logic sel);
    rd_stb = 1'b1; rd_sel = sel;
    step();
    rd_stb = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] eb;
    @(negedge clk);
    step(); step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 sr1", sr1, 8'h00);
    chk("R1 sr2", sr2, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 scl_hold", {7'b0, scl_hold}, 8'h00);
    pe = 1'b1; ack_en = 1'b1;
    step();

    // R2 R5 R7 R10 sweep: every event under both interrupt-enable values
    for (int ie = 0; ie < 2; ie++) begin
      write_ie(ie[0]);
      for (int idx = 0; idx < 9; idx++) begin
        eb = exp_bytes(idx);
        ev = 9'(1 << idx);
        step();
        ev = '0;
        chk("R2 sr1", sr1, eb[15:8]);
        chk("R2 sr2", sr2, eb[7:0]);
        step();
        chk("R7 irq", {7'b0, irq}, {7'b0, ie[0]});
        chk("R10 scl_hold", {7'b0, scl_hold}, {7'b0, (idx <= 4)});
        do_read(idx >= 4);
        chk("R5 rd_data", rd_data, (idx >= 4) ? eb[7:0] : eb[15:8]);
        chk("R5 sr1 cleared", sr1, 8'h00);
        chk("R5 sr2 cleared", sr2, 8'h00);
        step();
        chk("R7 irq low", {7'b0, irq}, 8'h00);
        chk("R10 hold low", {7'b0, scl_hold}, 8'h00);
      end
    end

    // R5 read of the other byte leaves flags alone; R3 summary from two bytes
    ev = 9'b1_0000_0001;
    step();
    ev = '0;
    do_read(1'b1);
    chk("R5 sr1 kept", sr1, 8'h81);
    chk("R5 sr2 read", rd_data, 8'h10);
    do_read(1'b0);
    chk("R3 summary clear", sr1, 8'h00);
    step();

    // R6 coincident event and read, interrupts enabled
    ev = 9'b0_0000_0100; rd_stb = 1'b1; rd_sel = 1'b0;
    step();
    ev = '0; rd_stb = 1'b0;
    chk("R6 rd_data", rd_data, 8'h88);
    chk("R6 sr1", sr1, 8'h00);
    chk("R6 irq", {7'b0, irq}, 8'h00);
    step();
    chk("R6 irq later", {7'b0, irq}, 8'h00);

    // R4 address match ignored without acknowledge
    ack_en = 1'b0;
    ev = 9'b0_0000_0010;
    step();
    ev = '0;
    chk("R4 sr1", sr1, 8'h00);
    step();
    chk("R4 irq", {7'b0, irq}, 8'h00);
    ack_en = 1'b1;

    // R11 DMA exception over all enable/done combinations
    write_ie(1'b0);
    for (int c = 0; c < 4; c++) begin
      dma_en = c[1]; dma_done = c[0];
      ev = 9'b0_0000_0100;
      step();
      ev = '0;
      step();
      chk("R11 hold", {7'b0, scl_hold}, {7'b0, !(c[1] && !c[0])});
      if (c[1] && !c[0]) begin
        dma_done = 1'b1;
        step();
        chk("R11 hold after done", {7'b0, scl_hold}, 8'h01);
      end
      do_read(1'b0);
      step();
      chk("R11 hold released", {7'b0, scl_hold}, 8'h00);
    end
    dma_en = 1'b0; dma_done = 1'b0;

    // R12 mode bits, not part of summary, not read-cleared
    write_ie(1'b1);
    lv_tx = 1'b1; lv_busy = 1'b1; lv_master = 1'b1;
    step();
    chk("R12 sr1 modes", sr1, 8'h32);
    step();
    chk("R12 no irq", {7'b0, irq}, 8'h00);
    do_read(1'b0);
    chk("R12 read value", rd_data, 8'h32);
    chk("R12 kept after read", sr1, 8'h32);
    lv_tx = 1'b0; lv_busy = 1'b0; lv_master = 1'b0;
    step();
    chk("R12 modes low", sr1, 8'h00);

    // R9 R8 disable clears flags and interrupt-enable
    ev = 9'b1_0000_0001;
    lv_busy = 1'b1;
    step();
    ev = '0;
    step();
    chk("R7 irq set", {7'b0, irq}, 8'h01);
    pe = 1'b0;
    step();
    chk("R9 sr1", sr1, 8'h00);
    chk("R9 sr2", sr2, 8'h00);
    chk("R9 irq", {7'b0, irq}, 8'h00);
    pe = 1'b1; lv_busy = 1'b0;
    step();
    ev = 9'b0_0010_0000;
    step();
    ev = '0;
    chk("R9 new event", sr2, 8'h02);
    step();
    chk("R8 ie stays off", {7'b0, irq}, 8'h00);
    write_ie(1'b1);
    step();
    chk("R8 ie rewritten", {7'b0, irq}, 8'h01);
    do_read(1'b1);
    step();
    chk("R7 irq drops", {7'b0, irq}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule